// File: doc/BRIEF.md
# Multi-Latency Execute Stage with Shared Result Bus

This block is the execute and writeback slice of a small speculative out-of-order core. A dispatcher hands it at most one operation per cycle. Each operation names one of five execution units (branch, load-address, integer ALU, floating add, floating multiply), a reorder-buffer tag and two 64-bit operands. Each unit is a pipeline with its own fixed depth. Units that finish in the same cycle then compete for one result bus, which broadcasts a single tag and value per cycle.

The winner is always the oldest tag, and tag age is compared with wraparound. A unit whose result loses keeps it in a one-entry holding register. While that register is occupied, the unit reports busy and refuses new work. If its pipeline has another result ready behind the held one, that pipeline freezes until the hold drains.

A flush input drops everything in flight in the same cycle. The arithmetic in each unit stands in for the real datapath, so that values can be traced end to end.

Top module: `exu_cluster`

## Requirements
- R1: A dispatch is taken when `disp_vld` is high, `flush` is low and the addressed unit is not busy. At most one operation enters per cycle. Unit codes on `disp_cls`: 0 branch, 1 load, 2 integer, 3 FP add, 4 FP multiply.
- R2: The execute depth is 1 cycle for branch, load and integer, 2 cycles for FP add and 3 cycles for FP multiply. An operation dispatched in cycle t on an idle bus is broadcast in cycle t+depth+1, and never earlier.
- R3: Broadcast values are computed as follows:
  - branch: value is `disp_b`, and `res_flag` is 1 exactly when `disp_a == disp_b`.
  - load: value is `a+b`.
  - integer: value is `a-b`.
  - FP add: value is `a+b`.
  - FP multiply: value is the low 64 bits of `a*b`.
  - `res_flag` is 0 for every class except branch.
- R4: When several results are ready in one cycle, the tag that is oldest modulo 2^5 wins. Tag x is older than tag y when `(x-y) mod 32 >= 16`.
- R5: A result that loses arbitration is held and broadcast later. Every accepted operation is broadcast exactly once, and the bus never carries a tag that was not accepted.
- R6: `unit_busy[u]` is high while unit u holds a result that lost arbitration. A dispatch to a busy unit is ignored and is never broadcast.
- R7: While `flush` is high, nothing is broadcast and any dispatch is ignored. Every operation in flight or held at that time is discarded. An operation dispatched after the flush completes normally.
- R8: Operations dispatched back to back into the same unit are all kept, including in cycles where that unit is also broadcasting.
- R9: While and after reset, `res_vld` is 0 and `unit_busy` is all zero.
- R10: A dispatch with a unit code of 5, 6 or 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight work |
| disp_vld | input | 1 | Dispatch request |
| disp_cls | input | 3 | Target unit code |
| disp_tag | input | 5 | Reorder-buffer tag |
| disp_a | input | 64 | First operand |
| disp_b | input | 64 | Second operand |
| unit_busy | output | 5 | Per-unit busy, bit index equals unit code |
| res_vld | output | 1 | Broadcast valid |
| res_tag | output | 5 | Tag of the broadcast result |
| res_val | output | 64 | Broadcast result value |
| res_flag | output | 1 | Branch taken flag |

## Verification
Single operations are sent one at a time to each unit on an idle bus. This pins the exact depth of every unit and its arithmetic.

Dispatches are staggered so that a 3-cycle, a 2-cycle and a 1-cycle operation all finish together. Tags are chosen either in order or across the wrap point, which separates oldest-first from fixed unit priority and from a plain unsigned comparison. The same collision also fills holding registers, so the busy flag and the dropping of a dispatch to a busy unit can be seen.

A long random stream of mixed classes, operands, busy-respecting dispatches and occasional flushes is scored tag by tag. It exposes lost, duplicated or early results and results that should have been discarded.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int unsigned TAG_W   = 5;
    localparam int unsigned DATA_W  = 64;
    localparam int unsigned CLS_W   = 3;
    localparam int unsigned N_UNITS = 5;

    localparam int unsigned U_BR   = 0;
    localparam int unsigned U_LD   = 1;
    localparam int unsigned U_INT  = 2;
    localparam int unsigned U_FADD = 3;
    localparam int unsigned U_FMUL = 4;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
        logic              flag;
    } res_t;

    // execute depth of each unit, result-bus write not included
    function automatic int unsigned unit_lat(input int unsigned u);
        case (u)
            U_FADD:  return 2;
            U_FMUL:  return 3;
            default: return 1;
        endcase
    endfunction

    // stand-in arithmetic per unit
    function automatic logic [DATA_W-1:0] unit_value(input int unsigned u,
                                                     input logic [DATA_W-1:0] a,
                                                     input logic [DATA_W-1:0] b);
        case (u)
            U_BR:    return b;
            U_LD:    return a + b;
            U_INT:   return a - b;
            U_FADD:  return a + b;
            U_FMUL:  return a * b;
            default: return '0;
        endcase
    endfunction

    // x older than y in a circular tag space
    function automatic logic tag_older(input logic [TAG_W-1:0] x,
                                       input logic [TAG_W-1:0] y);
        logic [TAG_W-1:0] d;
        d = x - y;
        return d[TAG_W-1];
    endfunction

endpackage

// File: rtl/exu_lane.sv
module exu_lane
    import exu_pkg::*;
#(
    parameter int unsigned UNIT = 0,
    parameter int unsigned LAT  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_vld,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              grant,
    output res_t              cand,
    output logic              busy
);

    res_t stg [LAT];
    res_t hold;
    res_t entry;
    res_t last;
    logic accept;
    logic stall;

    always_comb begin
        accept     = in_vld && !hold.vld;
        entry.vld  = accept;
        entry.tag  = in_tag;
        entry.val  = unit_value(UNIT, in_a, in_b);
        entry.flag = (UNIT == U_BR) && (in_a == in_b);
        last       = stg[LAT-1];
        stall      = last.vld && hold.vld && !grant;
        cand       = hold.vld ? hold : last;
        busy       = hold.vld;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < LAT; i++) stg[i] <= '0;
        end else if (!stall) begin
            stg[0] <= entry;
            for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hold <= '0;
        end else if (hold.vld) begin
            if (grant) hold <= last;
        end else if (last.vld && !grant) begin
            hold <= last;
        end
    end

    // R5: a held result that is not granted stays unchanged
    p_hold_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (hold.vld && !grant && !flush) |=> (hold == $past(hold)));

    // R5: a frozen pipeline keeps its finished result
    p_stall_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (stall && !flush) |=> (stg[LAT-1] == $past(stg[LAT-1])));

    // R8: an accepted operation always enters the first stage
    p_accept_enters_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && !flush) |=> (stg[0].vld && stg[0].tag == $past(in_tag)));

    // R6: a request to a busy unit does not enter it
    p_busy_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && busy && !flush) |=> !(stg[0].vld && stg[0].tag == $past(in_tag) && !$past(stall)));

endmodule

// File: rtl/exu_arb.sv
module exu_arb
    import exu_pkg::*;
#(
    parameter int unsigned N = N_UNITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req_vld,
    input  logic [TAG_W-1:0] req_tag [N],
    output logic [N-1:0]     grant
);

    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] best;
    logic [TAG_W-1:0] best_tag;
    logic             best_vld;

    always_comb begin
        best     = '0;
        best_tag = '0;
        best_vld = 1'b0;
        grant    = '0;
        for (int i = 0; i < N; i++) begin
            if (req_vld[i] && (!best_vld || tag_older(req_tag[i], best_tag))) begin
                best_vld = 1'b1;
                best_tag = req_tag[i];
                best     = IDX_W'(i);
            end
        end
        if (best_vld) grant[best] = 1'b1;
    end

    // R4: at most one unit drives the bus
    p_single_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5: the bus is never left idle while a result waits
    p_no_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (|req_vld) |-> (|grant));

    // R4: the granted tag is older than every other waiting tag
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (gi != gj) begin : g_pair
                p_oldest_r4: assert property (@(posedge clk) disable iff (rst)
                    (grant[gi] && req_vld[gj]) |-> tag_older(req_tag[gi], req_tag[gj]));
            end
        end
    end

endmodule

// File: rtl/exu_cluster.sv
module exu_cluster
    import exu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              disp_vld,
    input  logic [CLS_W-1:0]  disp_cls,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic [DATA_W-1:0] disp_a,
    input  logic [DATA_W-1:0] disp_b,
    output logic [N_UNITS-1:0] unit_busy,
    output logic              res_vld,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_val,
    output logic              res_flag
);

    res_t               cand [N_UNITS];
    logic [N_UNITS-1:0] cand_vld;
    logic [TAG_W-1:0]   cand_tag [N_UNITS];
    logic [N_UNITS-1:0] grant;
    res_t               win;
    res_t               bus_q;

    for (genvar gu = 0; gu < N_UNITS; gu++) begin : g_lane
        exu_lane #(
            .UNIT (gu),
            .LAT  (unit_lat(gu))
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .flush  (flush),
            .in_vld (disp_vld && !flush && (disp_cls == CLS_W'(gu))),
            .in_tag (disp_tag),
            .in_a   (disp_a),
            .in_b   (disp_b),
            .grant  (grant[gu]),
            .cand   (cand[gu]),
            .busy   (unit_busy[gu])
        );

        assign cand_vld[gu] = cand[gu].vld;
        assign cand_tag[gu] = cand[gu].tag;
    end

    exu_arb #(.N(N_UNITS)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req_vld (cand_vld),
        .req_tag (cand_tag),
        .grant   (grant)
    );

    always_comb begin
        win = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (grant[i]) win = cand[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) bus_q <= '0;
        else              bus_q <= win;
    end

    assign res_vld  = bus_q.vld && !flush;
    assign res_tag  = bus_q.tag;
    assign res_val  = bus_q.val;
    assign res_flag = bus_q.flag;

    // R7: the cycle after a flush is silent
    p_flush_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> !res_vld);

    // R9: nothing is busy right after reset
    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (unit_busy == '0 && !res_vld));

endmodule

// File: tb/exu_cluster_bench.sv
module exu_cluster_bench;
    import exu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        disp_vld;
    logic [2:0]  disp_cls;
    logic [4:0]  disp_tag;
    logic [63:0] disp_a;
    logic [63:0] disp_b;
    logic [4:0]  unit_busy;
    logic        res_vld;
    logic [4:0]  res_tag;
    logic [63:0] res_val;
    logic        res_flag;

    exu_cluster u_exu_cluster (
        .clk(clk), .rst(rst), .flush(flush), .disp_vld(disp_vld),
        .disp_cls(disp_cls), .disp_tag(disp_tag), .disp_a(disp_a),
        .disp_b(disp_b), .unit_busy(unit_busy), .res_vld(res_vld),
        .res_tag(res_tag), .res_val(res_val), .res_flag(res_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    longint      cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          n_bcast = 0;
    bit          pend [32];
    logic [63:0] e_val [32];
    bit          e_flag [32];
    longint      d_cyc [32];
    int          e_lat [32];
    longint      seen [32];
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_lat(input int c);
        if (c == 3) return 2;
        if (c == 4) return 3;
        return 1;
    endfunction

    function automatic logic [63:0] ref_val(input int c, input logic [63:0] a, input logic [63:0] b);
        case (c)
            0: return b;
            1: return a + b;
            2: return a - b;
            3: return a + b;
            default: return a * b;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // one cycle of input; returns whether the bench expects acceptance
    task automatic drive(input bit v, input int c, input int tag,
                         input logic [63:0] a, input logic [63:0] b,
                         input bit fl, output bit acc);
        @(negedge clk);
        acc      = 1'b0;
        flush    = fl;
        disp_vld = v;
        disp_cls = c[2:0];
        disp_tag = tag[4:0];
        disp_a   = a;
        disp_b   = b;
        if (fl) begin
            for (int i = 0; i < 32; i++) pend[i] = 1'b0;
        end
        if (v && !fl && c < 5) begin
            if (!unit_busy[c]) begin
                acc        = 1'b1;
                pend[tag]  = 1'b1;
                e_val[tag] = ref_val(c, a, b);
                e_flag[tag]= (c == 0) && (a == b);
                e_lat[tag] = ref_lat(c);
                d_cyc[tag] = cyc;
            end
        end
    endtask

    task automatic send(input int c, input int tag, input logic [63:0] a, input logic [63:0] b);
        bit acc;
        drive(1'b1, c, tag, a, b, 1'b0, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 64'd0, 64'd0, 1'b0, acc);
    endtask

    task automatic clr_seen();
        for (int i = 0; i < 32; i++) seen[i] = -1;
    endtask

    // result-bus monitor
    always @(negedge clk) begin
        #2;
        if (rst === 1'b0 && !done) begin
            if (flush) chk(!res_vld, "R7", "broadcast during flush", 64'(res_vld), 64'd0);
            if (res_vld) begin
                n_bcast++;
                seen[res_tag] = cyc;
                if (!pend[res_tag]) begin
                    chk(1'b0, "R5", "broadcast of tag not pending", 64'(res_tag), 64'd0);
                end else begin
                    chk(res_val == e_val[res_tag], "R3", "result value", res_val, e_val[res_tag]);
                    chk(res_flag == e_flag[res_tag], "R3", "branch flag", 64'(res_flag), 64'(e_flag[res_tag]));
                    chk(cyc - d_cyc[res_tag] >= e_lat[res_tag] + 1, "R2", "broadcast too early",
                        64'(cyc - d_cyc[res_tag]), 64'(e_lat[res_tag] + 1));
                    pend[res_tag] = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_use;
        int     next_tag;
        int     snap;
        bit     acc;
        seed_use = $urandom(32'd4711);
        rst = 1'b1; flush = 1'b0; disp_vld = 1'b0; disp_cls = '0;
        disp_tag = '0; disp_a = '0; disp_b = '0;
        for (int i = 0; i < 32; i++) pend[i] = 1'b0;
        clr_seen();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!res_vld, "R9", "res_vld in reset", 64'(res_vld), 64'd0);
        chk(unit_busy == 5'd0, "R9", "busy in reset", 64'(unit_busy), 64'd0);
        rst = 1'b0;
        idle(1);
        #1;
        chk(!res_vld, "R9", "res_vld after reset", 64'(res_vld), 64'd0);
        chk(unit_busy == 5'd0, "R9", "busy after reset", 64'(unit_busy), 64'd0);

        // depth and arithmetic of every unit on an idle bus (R2, R3)
        clr_seen();
        for (int c = 0; c < 5; c++) begin
            send(c, c + 1, 64'h1234_5678_9abc_def0 + 64'(c), (c == 0) ? 64'h1234_5678_9abc_def0 : 64'h0000_0003_0000_0007);
            idle(6);
            chk(seen[c+1] - d_cyc[c+1] == ref_lat(c) + 1, "R2", "exact depth on idle bus",
                64'(seen[c+1] - d_cyc[c+1]), 64'(ref_lat(c) + 1));
        end
        send(0, 6, 64'd10, 64'd11);
        idle(4);
        chk(seen[6] - d_cyc[6] == 2, "R3", "branch not taken broadcast", 64'(seen[6] - d_cyc[6]), 64'd2);

        // three-way collision, holds and busy (R4, R5, R6)
        clr_seen();
        send(4, 8, 64'd3, 64'd5);
        send(3, 9, 64'd7, 64'd9);
        send(2, 10, 64'd100, 64'd1);
        idle(1);
        @(negedge clk);
        #1;
        chk(unit_busy[2] == 1'b1, "R6", "integer unit busy after losing", 64'(unit_busy[2]), 64'd1);
        chk(unit_busy[3] == 1'b1, "R6", "fp add unit busy after losing", 64'(unit_busy[3]), 64'd1);
        flush = 1'b0; disp_vld = 1'b1; disp_cls = 3'd2; disp_tag = 5'd11;
        disp_a = 64'd1; disp_b = 64'd1;
        idle(8);
        chk(seen[8] == d_cyc[8] + 4, "R4", "oldest tag first", 64'(seen[8] - d_cyc[8]), 64'd4);
        chk(seen[9] == d_cyc[8] + 5, "R5", "held fp add later", 64'(seen[9] - d_cyc[8]), 64'd5);
        chk(seen[10] == d_cyc[8] + 6, "R5", "held integer last", 64'(seen[10] - d_cyc[8]), 64'd6);
        chk(seen[11] == -1, "R6", "dispatch to busy unit dropped", 64'(seen[11]), 64'hffff_ffff_ffff_ffff);
        chk(unit_busy == 5'd0, "R6", "busy clears after drain", 64'(unit_busy), 64'd0);

        // wraparound age (R4)
        clr_seen();
        send(4, 30, 64'd2, 64'd2);
        idle(1);
        send(2, 1, 64'd9, 64'd4);
        idle(6);
        chk(seen[30] == d_cyc[30] + 4, "R4", "tag 30 older than 1", 64'(seen[30] - d_cyc[30]), 64'd4);
        chk(seen[1] == d_cyc[30] + 5, "R4", "tag 1 after wrap", 64'(seen[1] - d_cyc[30]), 64'd5);
        clr_seen();
        send(4, 3, 64'd6, 64'd6);
        idle(1);
        send(2, 2, 64'd8, 64'd1);
        idle(6);
        chk(seen[2] == d_cyc[3] + 4, "R4", "older integer beats multiply", 64'(seen[2] - d_cyc[3]), 64'd4);
        chk(seen[3] == d_cyc[3] + 5, "R4", "younger multiply waits", 64'(seen[3] - d_cyc[3]), 64'd5);

        // back-to-back into one unit (R8, R1)
        clr_seen();
        send(2, 12, 64'd50, 64'd1);
        send(2, 13, 64'd50, 64'd2);
        send(2, 14, 64'd50, 64'd3);
        idle(5);
        chk(seen[12] == d_cyc[12] + 2, "R8", "first of burst", 64'(seen[12] - d_cyc[12]), 64'd2);
        chk(seen[13] == d_cyc[12] + 3, "R8", "second of burst", 64'(seen[13] - d_cyc[12]), 64'd3);
        chk(seen[14] == d_cyc[12] + 4, "R1", "third of burst", 64'(seen[14] - d_cyc[12]), 64'd4);

        // flush (R7)
        clr_seen();
        send(2, 19, 64'd5, 64'd4);
        send(4, 20, 64'd5, 64'd4);
        snap = n_bcast;
        drive(1'b1, 2, 22, 64'd1, 64'd2, 1'b1, acc);
        idle(6);
        chk(n_bcast == snap, "R7", "broadcasts after flush", 64'(n_bcast - snap), 64'd0);
        chk(seen[19] == -1 && seen[20] == -1 && seen[22] == -1, "R7", "flushed tags silent",
            64'(seen[19]), 64'hffff_ffff_ffff_ffff);
        send(2, 24, 64'd9, 64'd9);
        idle(4);
        chk(seen[24] == d_cyc[24] + 2, "R7", "normal after flush", 64'(seen[24] - d_cyc[24]), 64'd2);

        // unused codes (R10)
        clr_seen();
        for (int c = 5; c < 8; c++) begin
            drive(1'b1, c, 20 + c, 64'd1, 64'd1, 1'b0, acc);
        end
        idle(6);
        chk(seen[25] == -1 && seen[26] == -1 && seen[27] == -1, "R10", "unused unit codes ignored",
            64'(seen[25]), 64'hffff_ffff_ffff_ffff);

        // random mixed traffic
        next_tag = 0;
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2) begin
                drive(1'b0, 0, 0, 64'd0, 64'd0, 1'b1, acc);
            end else if (r < 80 && !pend[next_tag]) begin
                int c;
                logic [63:0] a, b;
                c = int'($urandom % 6);
                a = {$urandom, $urandom};
                b = ($urandom % 2) ? a : {$urandom, $urandom};
                drive(1'b1, c, next_tag, a, b, 1'b0, acc);
                if (acc) next_tag = (next_tag + 1) % 32;
            end else begin
                idle(1);
            end
        end
        idle(20);
        for (int t = 0; t < 32; t++) begin
            chk(!pend[t], "R5", "accepted tag never broadcast", 64'(pend[t]), 64'd0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule